// File: doc/BRIEF.md
# Interrupt-Steered Transfer Router

This block sits between a set of peripheral interrupt pulses and two consumers: the processor and a hardware data-mover. Each pulse is steered by a per-source enable bit. A source whose bit is clear raises an ordinary processor interrupt that carries its own index as the vector. A source whose bit is set becomes a pending transfer job instead. The router issues transfer jobs one at a time to the mover through a one-cycle request strobe. The mover answers each job with a completion pulse.

A 16-bit remaining-transfer count is decremented on every completion. When a completion brings the count down to zero, the source that started that transfer is handed to the processor with its own vector, which signals that the block move is finished. A stored count of zero means 65,536 transfers. Four 8-bit enable registers and the count are loaded through a simple write port. A few sources, such as non-maskable, overflow and error events, have no enable bit and always go to the processor.

Top module: `irq_xfer_router`

## Requirements
- R1: After reset, xfer_req and cpu_irq are 0, every enable bit is 0 (so any pulse goes to the processor) and the count is 0.
- R2: A pulse on a transfer-capable source whose enable bit is 1 produces no processor interrupt. When no transfer is outstanding, xfer_req rises exactly two clock edges after the pulse is sampled, with xfer_src equal to the source index.
- R3: A pulse on a source whose enable bit is 0 raises cpu_irq on the next clock edge, with cpu_vec equal to the source index.
- R4: Sources 0 to 15 are transfer-capable. Source k is enabled by bit 2*(k mod 4) of enable register k/4. Write select values 0 to 3 pick enable registers 0 to 3, taken from wr_data[7:0], and select value 4 loads the count from wr_data[15:0]. Odd bits of the enable registers have no effect. Sources 16 to 19 always go to the processor, whatever is written.
- R5: xfer_req is high for a single cycle per job. Only one job is outstanding at a time, and among pending jobs the lowest source index is issued first.
- R6: An enabled pulse that arrives while a job is outstanding stays pending. Its xfer_req follows only after xfer_done for the current job.
- R7: Each xfer_done while a job is outstanding decrements the count by one. An xfer_done with no job outstanding is ignored.
- R8: When a completion changes the count from 1 to 0, cpu_irq is raised with cpu_vec equal to the source of that job. Completions that leave the count non-zero raise no processor interrupt.
- R9: A stored count of 0 stands for 65,536: the completion interrupt follows the 65,536th transfer.
- R10: With several processor requests pending, cpu_vec shows the lowest index. cpu_ack clears the one shown, and a request stays raised until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pulse | input | 20 | One-cycle interrupt event per source |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0-3 enable registers, 4 count |
| wr_data | input | 16 | Write data |
| xfer_done | input | 1 | Completion of the outstanding transfer job |
| cpu_ack | input | 1 | Processor accepts the interrupt currently shown |
| xfer_req | output | 1 | One-cycle strobe issuing a transfer job |
| xfer_src | output | 4 | Source index of the issued or outstanding job |
| cpu_irq | output | 1 | Processor interrupt request |
| cpu_vec | output | 5 | Source index of the processor request shown |

## Verification
The checker assumes that the mover sends at most one xfer_done per issued job. To count jobs in flight, it follows xfer_req and xfer_done and treats a completion in the strobe cycle as valid. It also assumes that cpu_ack comes only while cpu_irq is high and that new pulses may change the vector that is shown. The stimulus drives completions only after it has seen a strobe, or deliberately while idle to exercise R7. It acknowledges only raised requests. In the long-count test it holds one source's pulse and the completion line high, so that jobs run back to back within these assumptions.

// File: rtl/xr_pkg.sv
package xr_pkg;

    localparam int XR_SEL_W = 3;

    typedef enum logic [XR_SEL_W-1:0] {
        XR_SEL_ENA0  = 3'd0,
        XR_SEL_ENA1  = 3'd1,
        XR_SEL_ENA2  = 3'd2,
        XR_SEL_ENA3  = 3'd3,
        XR_SEL_COUNT = 3'd4
    } xr_sel_e;

endpackage

// File: rtl/xr_lowest_pick.sv
module xr_lowest_pick #(
    parameter int W  = 16,
    parameter int IW = 4
) (
    input  logic [W-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    // scan downward so the lowest set position is written last
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/xr_cfg_regs.sv
module xr_cfg_regs
    import xr_pkg::*;
#(
    parameter int N_CAP = 16,
    parameter int N_ENR = 4,
    parameter int ENR_W = 8,
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [XR_SEL_W-1:0] wr_sel,
    input  logic [CNT_W-1:0]    wr_data,
    input  logic                cnt_dec,
    output logic [N_CAP-1:0]    cap_en,
    output logic                cnt_last
);
    localparam int SLOTS  = N_CAP / N_ENR;
    localparam int STRIDE = ENR_W / SLOTS;

    typedef struct packed {
        logic [N_CAP-1:0] en;
        logic [CNT_W-1:0] cnt;
    } cfg_t;

    cfg_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        // a completion wraps 0 -> all ones, which keeps the 0 = 2^CNT_W meaning
        if (cnt_dec) s_d.cnt = s_q.cnt - CNT_W'(1);
        if (wr_en) begin
            if (wr_sel == XR_SEL_COUNT) s_d.cnt = wr_data;
            // only assigned positions are stored; the others are dropped
            for (int k = 0; k < N_CAP; k++) begin
                if (wr_sel == XR_SEL_W'(k / SLOTS))
                    s_d.en[k] = wr_data[(k % SLOTS) * STRIDE];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cap_en   = s_q.en;
    assign cnt_last = (s_q.cnt == CNT_W'(1));
endmodule

// File: rtl/xr_cpu_queue.sv
module xr_cpu_queue #(
    parameter int N_SRC = 20,
    parameter int IW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] raise,
    input  logic             ack,
    output logic             irq,
    output logic [IW-1:0]    vec
);
    typedef struct packed {
        logic [N_SRC-1:0] pend;
    } cq_t;

    cq_t s_d, s_q;
    logic          top_any;
    logic [IW-1:0] top_idx;

    xr_lowest_pick #(.W(N_SRC), .IW(IW)) u_pick (
        .req (s_q.pend),
        .any (top_any),
        .idx (top_idx)
    );

    always_comb begin
        s_d = s_q;
        if (ack && top_any) s_d.pend[top_idx] = 1'b0;
        // a fresh event on the same line survives the acknowledge
        s_d.pend = s_d.pend | raise;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq = top_any;
    assign vec = top_idx;
endmodule

// File: rtl/irq_xfer_router.sv
module irq_xfer_router
    import xr_pkg::*;
#(
    parameter  int N_SRC = 20,
    parameter  int N_CAP = 16,
    parameter  int N_ENR = 4,
    parameter  int ENR_W = 8,
    parameter  int CNT_W = 16,
    localparam int IW    = $clog2(N_SRC),
    localparam int CW    = $clog2(N_CAP)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_SRC-1:0]    irq_pulse,
    input  logic                wr_en,
    input  logic [XR_SEL_W-1:0] wr_sel,
    input  logic [CNT_W-1:0]    wr_data,
    input  logic                xfer_done,
    input  logic                cpu_ack,
    output logic                xfer_req,
    output logic [CW-1:0]       xfer_src,
    output logic                cpu_irq,
    output logic [IW-1:0]       cpu_vec
);
    typedef struct packed {
        logic [N_CAP-1:0] pend;
        logic             busy;
        logic [CW-1:0]    cur;
        logic             req;
    } eng_t;

    eng_t s_d, s_q;

    logic [N_CAP-1:0] cap_en;
    logic             cnt_last;
    logic [N_SRC-1:0] to_cpu;
    logic [N_CAP-1:0] to_xfer;
    logic [N_SRC-1:0] fin_raise;
    logic             job_any;
    logic [CW-1:0]    job_idx;
    logic             done_ok;

    xr_cfg_regs #(
        .N_CAP (N_CAP),
        .N_ENR (N_ENR),
        .ENR_W (ENR_W),
        .CNT_W (CNT_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .cnt_dec  (done_ok),
        .cap_en   (cap_en),
        .cnt_last (cnt_last)
    );

    // steer each event line to one of the two consumers
    for (genvar i = 0; i < N_SRC; i++) begin : g_route
        if (i < N_CAP) begin : g_cap
            assign to_cpu[i]  = irq_pulse[i] & ~cap_en[i];
            assign to_xfer[i] = irq_pulse[i] &  cap_en[i];
        end else begin : g_fixed
            assign to_cpu[i] = irq_pulse[i];
        end
    end

    xr_lowest_pick #(.W(N_CAP), .IW(CW)) u_job_pick (
        .req (s_q.pend),
        .any (job_any),
        .idx (job_idx)
    );

    assign done_ok = s_q.busy & xfer_done;

    // the last completion returns the job's own source to the processor
    always_comb begin
        fin_raise = '0;
        if (done_ok && cnt_last) fin_raise[s_q.cur] = 1'b1;
    end

    always_comb begin
        s_d     = s_q;
        s_d.req = 1'b0;
        if (done_ok) s_d.busy = 1'b0;
        if (!s_q.busy && job_any) begin
            s_d.busy          = 1'b1;
            s_d.req           = 1'b1;
            s_d.cur           = job_idx;
            s_d.pend[job_idx] = 1'b0;
        end
        s_d.pend = s_d.pend | to_xfer;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    xr_cpu_queue #(.N_SRC(N_SRC), .IW(IW)) u_cpu (
        .clk   (clk),
        .rst_n (rst_n),
        .raise (to_cpu | fin_raise),
        .ack   (cpu_ack),
        .irq   (cpu_irq),
        .vec   (cpu_vec)
    );

    assign xfer_req = s_q.req;
    assign xfer_src = s_q.cur;
endmodule

// File: rtl/xr_router_chk.sv
module xr_router_chk #(
    parameter int N_SRC = 20,
    parameter int IW    = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] irq_pulse,
    input logic             xfer_done,
    input logic             cpu_ack,
    input logic             xfer_req,
    input logic             cpu_irq,
    input logic [IW-1:0]    cpu_vec
);
    logic out_q;

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= (out_q | xfer_req) & ~xfer_done;
    end

    // R5
    xfer_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |=> !xfer_req);

    // R5
    one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> !out_q);

    // R10
    cpu_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq && !cpu_ack) |=> cpu_irq);

    // R10
    cpu_vec_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq && !cpu_ack && !(|irq_pulse) && !xfer_done) |=> $stable(cpu_vec));

    // R8
    cpu_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_irq) |-> ($past(|irq_pulse) || $past(xfer_done && (out_q || xfer_req))));
endmodule

bind irq_xfer_router xr_router_chk #(.N_SRC(N_SRC), .IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_pulse (irq_pulse),
    .xfer_done (xfer_done),
    .cpu_ack   (cpu_ack),
    .xfer_req  (xfer_req),
    .cpu_irq   (cpu_irq),
    .cpu_vec   (cpu_vec)
);

// File: tb/tb_irq_xfer_router.sv
`timescale 1ns/1ps
module tb_irq_xfer_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] irq_pulse = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        xfer_done = 1'b0;
    logic        cpu_ack = 1'b0;
    logic        xfer_req;
    logic [3:0]  xfer_src;
    logic        cpu_irq;
    logic [4:0]  cpu_vec;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    irq_xfer_router dut (
        .clk(clk), .rst_n(rst_n), .irq_pulse(irq_pulse),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .xfer_done(xfer_done), .cpu_ack(cpu_ack),
        .xfer_req(xfer_req), .xfer_src(xfer_src),
        .cpu_irq(cpu_irq), .cpu_vec(cpu_vec)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000 && !finished) begin
            finished = 1'b1;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=190000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; irq_pulse = '0; xfer_done = 1'b0; cpu_ack = 1'b0; wr_en = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic wr(input int sel, input int data);
        wr_en = 1'b1; wr_sel = 3'(sel); wr_data = 16'(data);
        step();
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [19:0] m);
        irq_pulse = m;
        step();
        irq_pulse = '0;
    endtask

    task automatic done1();
        xfer_done = 1'b1;
        step();
        xfer_done = 1'b0;
    endtask

    task automatic ack1();
        cpu_ack = 1'b1;
        step();
        cpu_ack = 1'b0;
    endtask

    // pulse one enabled source, observe the job strobe, then complete it
    task automatic xfer(input int src, input string tag);
        pulse(20'(1) << src);
        step();
        chk({tag, " strobe"}, int'(xfer_req), 1);
        chk({tag, " source"}, int'(xfer_src), src);
        done1();
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 xfer_req idle", int'(xfer_req), 0);
        chk("R1 cpu_irq idle", int'(cpu_irq), 0);
        pulse(20'(1) << 4);
        chk("R1 default to cpu", int'(cpu_irq), 1);
        chk("R1 default vec", int'(cpu_vec), 4);
        step();
        chk("R1 no job when disabled", int'(xfer_req), 0);
        ack1();
        chk("R1 cleared after ack", int'(cpu_irq), 0);
    endtask

    task automatic t_cpu_route();
        do_reset();
        pulse((20'(1) << 7) | (20'(1) << 3));
        chk("R3 cpu raised", int'(cpu_irq), 1);
        chk("R10 lowest first", int'(cpu_vec), 3);
        step();
        chk("R10 held until ack", int'(cpu_irq), 1);
        ack1();
        chk("R10 next vec", int'(cpu_vec), 7);
        ack1();
        chk("R10 queue empty", int'(cpu_irq), 0);
    endtask

    task automatic t_xfer_route();
        do_reset();
        wr(1, 16'h0010);
        wr(4, 5);
        pulse(20'(1) << 6);
        chk("R2 no cpu irq", int'(cpu_irq), 0);
        chk("R2 no strobe yet", int'(xfer_req), 0);
        step();
        chk("R2 strobe", int'(xfer_req), 1);
        chk("R2 source", int'(xfer_src), 6);
        step();
        chk("R5 single-cycle strobe", int'(xfer_req), 0);
        done1();
        chk("R8 no irq before zero", int'(cpu_irq), 0);
    endtask

    task automatic t_priority();
        do_reset();
        wr(0, 16'h0010);
        wr(1, 16'h0004);
        wr(2, 16'h0004);
        wr(4, 100);
        pulse((20'(1) << 9) | (20'(1) << 5));
        step();
        chk("R5 lowest issued", int'(xfer_src), 5);
        chk("R5 strobe", int'(xfer_req), 1);
        irq_pulse = 20'(1) << 2;
        step();
        irq_pulse = '0;
        chk("R5 strobe drops", int'(xfer_req), 0);
        step(); step();
        chk("R6 waits while busy", int'(xfer_req), 0);
        done1();
        step();
        chk("R6 issued after done", int'(xfer_req), 1);
        chk("R5 pending lowest", int'(xfer_src), 2);
        done1();
        step();
        chk("R5 last pending", int'(xfer_src), 9);
        done1();
        step();
        chk("R5 no more jobs", int'(xfer_req), 0);
        chk("R8 count nonzero no irq", int'(cpu_irq), 0);
    endtask

    task automatic t_count();
        do_reset();
        wr(1, 16'h0010);
        wr(4, 3);
        xfer(6, "R7 t1");
        chk("R7 after first", int'(cpu_irq), 0);
        xfer(6, "R7 t2");
        chk("R7 after second", int'(cpu_irq), 0);
        xfer(6, "R8 t3");
        chk("R8 zero raises irq", int'(cpu_irq), 1);
        chk("R8 vector of source", int'(cpu_vec), 6);
        ack1();
        wr(4, 2);
        done1(); done1(); done1();
        chk("R7 idle done no job", int'(xfer_req), 0);
        xfer(6, "R7 t4");
        chk("R7 idle done ignored", int'(cpu_irq), 0);
        xfer(6, "R7 t5");
        chk("R7 zero after two", int'(cpu_irq), 1);
        ack1();
    endtask

    task automatic t_mapping();
        do_reset();
        wr(0, 16'h00AA);
        wr(4, 50);
        pulse(20'h0000F);
        chk("R4 odd bits ignored", int'(cpu_irq), 1);
        for (int v = 0; v < 4; v++) begin
            chk("R4 odd bits vec", int'(cpu_vec), v);
            chk("R4 odd bits no job", int'(xfer_req), 0);
            ack1();
        end
        chk("R4 all drained", int'(cpu_irq), 0);
        for (int r = 0; r < 4; r++) wr(r, 16'h00FF);
        pulse(20'(1) << 17);
        chk("R4 fixed source cpu", int'(cpu_irq), 1);
        chk("R4 fixed source vec", int'(cpu_vec), 17);
        step();
        chk("R4 fixed source no job", int'(xfer_req), 0);
        ack1();
        xfer(15, "R4 source15 reg3 bit6");
        chk("R4 source15 not cpu", int'(cpu_irq), 0);
        wr(3, 16'h0080);
        pulse(20'(1) << 15);
        chk("R4 bit7 not mapped", int'(cpu_irq), 1);
        chk("R4 bit7 vec", int'(cpu_vec), 15);
        ack1();
    endtask

    task automatic t_wrap();
        int n;
        do_reset();
        wr(0, 16'h0004);
        wr(4, 0);
        irq_pulse = 20'(1) << 1;
        xfer_done = 1'b1;
        n = 0;
        for (int i = 0; i < 140000; i++) begin
            step();
            if (cpu_irq) break;
            if (xfer_req) n++;
        end
        irq_pulse = '0;
        chk("R9 zero means 65536", n, 65536);
        chk("R9 vector", int'(cpu_vec), 1);
        step(); step(); step();
        xfer_done = 1'b0;
        ack1();
    endtask

    initial begin
        t_reset();
        t_cpu_route();
        t_xfer_route();
        t_priority();
        t_count();
        t_mapping();
        t_wrap();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule